// File: doc/BRIEF.md
# Reference Clock Loss Supervisor

This block decides whether a frequency-multiplying loop may still be considered locked while its reference input misbehaves. The reference is a slow, possibly intermittent clock that is brought into a steady local timing domain by a flop chain. Each rising edge restarts a gap counter, and the spacing between consecutive edges is stored as the learned period. When edges stop arriving, the block keeps reporting lock and keeps the downstream clocks enabled. It drops lock only at a hard limit on the gap, or when the reference comes back in a way that forces a fresh acquisition.

Short outages can be ridden through when clock skipping is enabled and the reference returns inside the skip window. If skipping is off, or the outage ran past the skip window, lock is withdrawn for a relock interval once the reference returns. An edge that arrives noticeably early counts as a period change and drops lock at once. A change on the mode-select pins drops lock too. The third mode pin does so only when its configuration code marks it as a live selector. While unlocked, the gate enable for the output clocks is governed by a clock-out-on-unlock setting.

Top module: `refclk_loss_supervisor`

## Requirements
- R1: While reset is held, and in the cycle after it, `locked` is 0 and `gate_en` equals `clkout_on_unlock`.
- R2: After the first synchronised reference rising edge, `locked` stays 0 for at least RELOCK_LEN cycles. `locked` then rises for one cycle in which `gate_en` is still governed by the unlocked rule, and `gate_en` rises in the following cycle.
- R3: Whenever `locked` is 0, `gate_en` equals `clkout_on_unlock`.
- R4: While the reference is absent and the gap since its last rising edge is below HARD_LIM, `locked` and `gate_en` remain 1.
- R5: When the gap since the last rising edge reaches HARD_LIM cycles, `locked` falls in the next cycle, whatever `skip_en` is.
- R6: If the reference returns with a gap of at most SKIP_WIN cycles and `skip_en` is 1, `locked` and `gate_en` never fall.
- R7: If the reference returns with `skip_en` 0, or after a gap larger than SKIP_WIN but below HARD_LIM, `locked` falls on the returning edge and comes back after the relock interval.
- R8: A rising edge arriving more than TOL cycles earlier than the learned period drops `locked` at once.
- R9: Any change of `mode_sel` causes `locked` to be 0 in the following cycle.
- R10: A change of `mode_aux` drops lock only when `aux_cfg` is 3, 4, 5 or 6. For any other code, the change has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local steady timing clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Asynchronous low-frequency reference clock |
| skip_en | input | 1 | Allow short reference outages to be ridden through |
| clkout_on_unlock | input | 1 | Keep output clocks enabled while unlocked |
| mode_sel | input | 2 | Primary mode-select pins, any change forces relock |
| mode_aux | input | 1 | Third mode pin |
| aux_cfg | input | 3 | Role code of the third mode pin (3..6 make it a live selector) |
| locked | output | 1 | Lock status |
| gate_en | output | 1 | Enable for downstream clock outputs |

## Verification
The two functions that can fall in the same cycle are a skip-window return of the reference with skipping enabled, which on its own would keep lock, and a mode-select change, which forces relock. The bench flips `mode_sel` two cycles after restarting the reference, which is the cycle in which the synchronised edge reaches the state machine. The case passes only if lock is dropped, because a mode change must win over a return that would otherwise be ridden through. Random outages of short, medium and long length are also drawn, with random skip settings, and each is classified against the two windows.

// File: rtl/rls_pkg.sv
package rls_pkg;

    typedef enum logic [2:0] {
        ST_UNLOCK  = 3'd0,
        ST_RELOCK  = 3'd1,
        ST_CLEAN   = 3'd2,
        ST_LOCKED  = 3'd3,
        ST_MISSING = 3'd4
    } lock_state_e;

    typedef struct packed {
        logic hard;     // gap reached the hard limit
        logic overdue;  // gap exceeds learned period plus tolerance
        logic early;    // edge came early versus learned period
        logic in_skip;  // gap still inside the skip window
    } gap_flags_t;

    localparam int AUX_CFG_W = 3;

    // Third mode pin acts as a selector for codes 3..6
    function automatic logic aux_watch_active(input logic [AUX_CFG_W-1:0] cfg);
        return (cfg >= 3'd3) && (cfg <= 3'd6);
    endfunction

    function automatic logic holds_lock(input lock_state_e st);
        return (st == ST_CLEAN) || (st == ST_LOCKED) || (st == ST_MISSING);
    endfunction

    function automatic logic runs_output(input lock_state_e st);
        return (st == ST_LOCKED) || (st == ST_MISSING);
    endfunction

endpackage

// File: rtl/rls_edge_sync.sv
module rls_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_raw,
    output logic rise
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], ref_raw};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/rls_gap_timer.sv
module rls_gap_timer
    import rls_pkg::*;
#(
    parameter int HARD_LIM = 8388608,
    parameter int SKIP_WIN = 1000000,
    parameter int TOL      = 4,
    parameter int CNT_W    = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise,
    input  logic             clear,
    input  logic             latch_en,
    output logic [CNT_W-1:0] gap,
    output gap_flags_t       flags
);
    localparam logic [CNT_W-1:0] HARD_C = CNT_W'(HARD_LIM);
    localparam logic [CNT_W-1:0] SKIP_C = CNT_W'(SKIP_WIN);
    localparam logic [CNT_W:0]   TOL_C  = (CNT_W+1)'(TOL);

    logic [CNT_W-1:0] period;
    logic             seen;
    logic             pvalid;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap    <= '0;
            period <= '0;
            seen   <= 1'b0;
            pvalid <= 1'b0;
        end else begin
            if (rise)              gap <= '0;
            else if (gap != HARD_C) gap <= gap + 1'b1;

            if (clear) begin
                pvalid <= 1'b0;
                seen   <= rise;
            end else if (rise) begin
                seen <= 1'b1;
                if (latch_en && seen) begin
                    period <= gap;
                    pvalid <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        flags.hard    = (gap >= HARD_C);
        flags.in_skip = (gap <= SKIP_C);
        flags.overdue = pvalid && ({1'b0, gap} > ({1'b0, period} + TOL_C));
        flags.early   = rise && pvalid && (({1'b0, gap} + TOL_C) < {1'b0, period});
    end
endmodule

// File: rtl/rls_mode_watch.sv
module rls_mode_watch
    import rls_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SEL_W-1:0]     mode_sel,
    input  logic                 mode_aux,
    input  logic [AUX_CFG_W-1:0] aux_cfg,
    output logic                 change
);
    logic [SEL_W-1:0] sel_q;
    logic             aux_q;

    // Loaded during reset too, so no change is seen on release
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= mode_sel;
            aux_q <= mode_aux;
        end else begin
            sel_q <= mode_sel;
            aux_q <= mode_aux;
        end
    end

    assign change = (mode_sel != sel_q) ||
                    (aux_watch_active(aux_cfg) && (mode_aux != aux_q));
endmodule

// File: rtl/rls_lock_fsm.sv
module rls_lock_fsm
    import rls_pkg::*;
#(
    parameter int RELOCK_LEN = 256
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rise,
    input  logic        skip_en,
    input  logic        mode_change,
    input  gap_flags_t  flags,
    output lock_state_e state
);
    localparam int RC_W = $clog2(RELOCK_LEN + 1);
    localparam logic [RC_W-1:0] RC_LAST = RC_W'(RELOCK_LEN - 1);

    lock_state_e     nxt;
    logic [RC_W-1:0] rc;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_UNLOCK:  if (rise) nxt = ST_RELOCK;
            ST_RELOCK: begin
                if (flags.hard)        nxt = ST_UNLOCK;
                else if (rc == RC_LAST) nxt = ST_CLEAN;
            end
            ST_CLEAN:   nxt = flags.hard ? ST_UNLOCK : ST_LOCKED;
            ST_LOCKED: begin
                if (flags.hard)         nxt = ST_UNLOCK;
                else if (flags.early)   nxt = ST_RELOCK;
                else if (flags.overdue) nxt = ST_MISSING;
            end
            ST_MISSING: begin
                if (flags.hard) nxt = ST_UNLOCK;
                else if (rise)  nxt = (skip_en && flags.in_skip) ? ST_LOCKED : ST_RELOCK;
            end
            default:    nxt = ST_UNLOCK;
        endcase
        if (mode_change && (state != ST_UNLOCK) && (nxt != ST_UNLOCK))
            nxt = ST_RELOCK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_UNLOCK;
            rc    <= '0;
        end else begin
            state <= nxt;
            rc    <= (state == ST_RELOCK && nxt == ST_RELOCK && !mode_change) ? rc + 1'b1 : '0;
        end
    end
endmodule

// File: rtl/refclk_loss_supervisor.sv
module refclk_loss_supervisor
    import rls_pkg::*;
#(
    parameter int HARD_LIM   = 8388608,
    parameter int SKIP_WIN   = 1000000,
    parameter int RELOCK_LEN = 256,
    parameter int TOL        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_in,
    input  logic       skip_en,
    input  logic       clkout_on_unlock,
    input  logic [1:0] mode_sel,
    input  logic       mode_aux,
    input  logic [2:0] aux_cfg,
    output logic       locked,
    output logic       gate_en
);
    localparam int CNT_W = $clog2(HARD_LIM + 1);

    logic             rise;
    logic             mode_change;
    logic [CNT_W-1:0] gap;
    gap_flags_t       flags;
    lock_state_e      state;

    rls_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .ref_raw(ref_in), .rise(rise)
    );

    rls_gap_timer #(
        .HARD_LIM(HARD_LIM), .SKIP_WIN(SKIP_WIN), .TOL(TOL), .CNT_W(CNT_W)
    ) u_gap (
        .clk(clk), .rst(rst), .rise(rise),
        .clear(state == ST_UNLOCK),
        .latch_en((state == ST_RELOCK) || (state == ST_CLEAN) || (state == ST_LOCKED)),
        .gap(gap), .flags(flags)
    );

    rls_mode_watch #(.SEL_W(2)) u_mode (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .mode_aux(mode_aux),
        .aux_cfg(aux_cfg), .change(mode_change)
    );

    rls_lock_fsm #(.RELOCK_LEN(RELOCK_LEN)) u_fsm (
        .clk(clk), .rst(rst), .rise(rise), .skip_en(skip_en),
        .mode_change(mode_change), .flags(flags), .state(state)
    );

    assign locked  = holds_lock(state);
    assign gate_en = runs_output(state) || clkout_on_unlock;
endmodule

// File: rtl/refclk_loss_supervisor_chk.sv
module refclk_loss_supervisor_chk #(
    parameter int HARD_LIM = 8388608,
    parameter int CNT_W    = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             locked,
    input logic             gate_en,
    input logic             clkout_on_unlock,
    input logic [1:0]       mode_sel,
    input logic [CNT_W-1:0] gap
);
    p_gate_unlocked_r3: assert property (@(posedge clk) disable iff (rst)
        (!locked) |-> (gate_en == clkout_on_unlock));

    p_clean_before_gate_r2: assert property (@(posedge clk) disable iff (rst)
        ($rose(gate_en) && !clkout_on_unlock) |-> $past(locked));

    p_hard_timeout_r5: assert property (@(posedge clk) disable iff (rst)
        (gap >= CNT_W'(HARD_LIM)) |=> !locked);

    p_mode_change_r9: assert property (@(posedge clk) disable iff (rst)
        (mode_sel != $past(mode_sel)) |=> !locked);
endmodule

bind refclk_loss_supervisor refclk_loss_supervisor_chk #(
    .HARD_LIM(HARD_LIM), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst(rst), .locked(locked), .gate_en(gate_en),
    .clkout_on_unlock(clkout_on_unlock), .mode_sel(mode_sel), .gap(gap)
);

// File: tb/refclk_loss_supervisor_test.sv
module refclk_loss_supervisor_test;
    localparam int HARD   = 4000;
    localparam int SKIP   = 1000;
    localparam int RELOCK = 64;
    localparam int TOL    = 2;
    localparam int HALF   = 20;

    logic       clk = 0;
    logic       rst = 1;
    logic       ref_in = 0;
    logic       skip_en = 0;
    logic       clkout_on_unlock = 0;
    logic [1:0] mode_sel = 0;
    logic       mode_aux = 0;
    logic [2:0] aux_cfg = 0;
    logic       locked, gate_en;

    int  n_chk = 0, n_err = 0;
    bit  finished = 0;
    bit  ref_run = 0, force_restart = 0;
    int  ph = 0;
    bit  seen_unlock = 0, seen_gate_low = 0;

    always #4 clk = ~clk;

    refclk_loss_supervisor #(
        .HARD_LIM(HARD), .SKIP_WIN(SKIP), .RELOCK_LEN(RELOCK), .TOL(TOL)
    ) uut (
        .clk(clk), .rst(rst), .ref_in(ref_in), .skip_en(skip_en),
        .clkout_on_unlock(clkout_on_unlock), .mode_sel(mode_sel),
        .mode_aux(mode_aux), .aux_cfg(aux_cfg), .locked(locked), .gate_en(gate_en)
    );

    // reference generator
    initial forever begin
        @(negedge clk);
        if (!ref_run) begin
            ref_in = 0; ph = 0;
        end else begin
            if (force_restart) begin ph = 0; force_restart = 0; end
            ref_in = (ph < HALF);
            ph = (ph + 1) % (2 * HALF);
        end
    end

    always @(negedge clk) begin
        if (!locked)  seen_unlock = 1;
        if (!gate_en) seen_gate_low = 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr_flags();
        @(posedge clk); seen_unlock = 0; seen_gate_low = 0;
    endtask

    function automatic bit expect_drop(input int cat, input bit sk);
        return (cat == 2) || !(sk && cat == 0);
    endfunction

    // cat 0 short, 1 mid, 2 long
    task automatic outage(input int g, input int cat, input bit sk);
        bit gap_drop;
        cyc(400);
        skip_en = sk;
        clr_flags();
        @(negedge clk); ref_run = 0;
        cyc(g);
        gap_drop = seen_unlock;
        if (cat == 2) begin
            chk(gap_drop == 1, "R5 hard timeout drops lock", gap_drop, 1);
            chk(gate_en == clkout_on_unlock, "R3 gate while unlocked", gate_en, clkout_on_unlock);
        end else begin
            chk(gap_drop == 0 && seen_gate_low == 0, "R4 lock held while absent", gap_drop, 0);
        end
        ref_run = 1;
        cyc(300);
        if (cat != 2)
            chk(seen_unlock == expect_drop(cat, sk),
                (sk && cat == 0) ? "R6 skip ride-through" : "R7 relock on return",
                seen_unlock, expect_drop(cat, sk));
        chk(locked == 1, "R7 relocked after return", locked, 1);
    endtask

    initial begin
        void'($urandom(32'd7321));
        cyc(3);
        chk(locked == 0 && gate_en == 0, "R1 during reset", {locked, gate_en}, 0);
        @(negedge clk); rst = 0;
        @(negedge clk);
        chk(locked == 0 && gate_en == 0, "R1 after reset", {locked, gate_en}, 0);

        // R2 acquisition
        begin
            int t = 0;
            bit g_at, g_next;
            ref_run = 1;
            while (!locked && t < 1000) begin @(negedge clk); t++; end
            g_at = gate_en;
            @(negedge clk); g_next = gate_en;
            chk(t >= RELOCK, "R2 relock interval length", t, RELOCK);
            chk(g_at == 0, "R2 clean cycle gate held", g_at, 0);
            chk(g_next == 1, "R2 gate released after clean", g_next, 1);
        end

        // directed outages
        outage(500, 0, 1);
        outage(500, 0, 0);
        outage(2000, 1, 1);
        outage(4300, 2, 1);
        clkout_on_unlock = 1;
        outage(4300, 2, 0);
        clkout_on_unlock = 0;

        // R8 early edge
        cyc(400);
        clr_flags();
        while (ph != 30) @(posedge clk);
        force_restart = 1;
        cyc(12);
        chk(seen_unlock == 1, "R8 early edge unlock", seen_unlock, 1);
        cyc(300);
        chk(locked == 1, "R8 relock after glitch", locked, 1);

        // R9 mode_sel change
        @(negedge clk); mode_sel = 2'd2;
        cyc(3);
        chk(locked == 0, "R9 mode change unlock", locked, 0);
        cyc(300);

        // R10 aux change ignored for code 0, honoured for 5
        aux_cfg = 3'd0;
        clr_flags();
        @(negedge clk); mode_aux = 1;
        cyc(200);
        chk(seen_unlock == 0, "R10 aux ignored cfg0", seen_unlock, 0);
        aux_cfg = 3'd5;
        cyc(5);
        @(negedge clk); mode_aux = 0;
        cyc(3);
        chk(locked == 0, "R10 aux honoured cfg5", locked, 0);
        cyc(300);

        // coincidence: skip return and mode change in same cycle
        aux_cfg = 3'd0;
        skip_en = 1;
        cyc(400);
        clr_flags();
        @(negedge clk); ref_run = 0;
        cyc(300);
        ref_run = 1;
        cyc(2);
        mode_sel = 2'd1;
        cyc(20);
        chk(seen_unlock == 1, "R9 mode change wins over R6 skip", seen_unlock, 1);
        cyc(300);

        // random outages
        for (int i = 0; i < 10; i++) begin
            int cat = $urandom_range(2, 0);
            bit sk = 1'($urandom_range(1, 0));
            int g = (cat == 0) ? $urandom_range(800, 100) :
                    (cat == 1) ? $urandom_range(3500, 1200) : $urandom_range(4600, 4300);
            outage(g, cat, sk);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule